// File: doc/BRIEF.md
# Functional Unit Issue and Operand Handshake Manager

This block sits in front of a 16-bit add/pass datapath and follows a single instruction from issue until its result has been written back. An issue pulse captures the operation code and its option flags: invert operand a, force operand a to zero, and an immediate value with its valid bit. From the next cycle the block reports busy. It then asks for each source operand through its own release/go handshake and feeds the collected operands to the datapath. The result is offered through a write release/go handshake.

A port that is masked, or whose operand is replaced by zero (port a) or by the immediate (port b), never raises its release. Busy stays high until the result has been accepted, so a result cannot be dropped. The issuer must keep issue low while busy is high and must hold the read mask stable during that time.

Top module: `fu_handshake_unit`

## Requirements
- R1: Busy rises on the cycle after an accepted issue pulse. It stays high until write go arrives while write release is high, and it falls on the cycle after that write go.
- R2: After reset, busy, both read releases and write release are low. Busy never rises unless issue was high in the previous cycle.
- R3: The operation code, invert-a, zero-a, immediate value and immediate-valid inputs are sampled in the issue cycle. Changing them afterwards has no effect on the result.
- R4: Each required read release rises on the cycle after issue. It stays high through any number of stall cycles until that port's go is seen.
- R5: A read release falls on the cycle after its go and does not rise again for the same instruction.
- R6: Read go is accepted in the first cycle its release is high. The operand value on the source input in that go cycle is the one used.
- R7: Read-mask bit 0 (port a) or bit 1 (port b), when high at issue, keeps that port's release low. The masked operand is taken as zero, unless port b carries a valid immediate.
- R8: With zero-a set, port a raises no release and operand a is zero. With immediate-valid set, port b raises no release and operand b is the captured immediate.
- R9: With invert-a set, operand a is bitwise inverted after zero selection and before the operation. For example, inverted 5 plus 2 gives 65532.
- R10: Operation code 1 adds a and b modulo 2^16. Any other code (0 is the nominal pass) returns the processed operand a.
- R11: Write release rises on the cycle after the last required operand is collected, or on the second cycle after issue when no operand is required. The result stays stable on the data output until write go. Read go and write go are ignored while their release is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | One-cycle instruction issue pulse |
| op_i | input | 2 | Operation code (1 add, others pass a) |
| inv_a_i | input | 1 | Invert operand a |
| zero_a_i | input | 1 | Replace operand a with zero |
| imm_i | input | 16 | Immediate value for operand b |
| imm_valid_i | input | 1 | Replace operand b with the immediate |
| rd_mask_i | input | 2 | Per-port read suppression (bit 0 a, bit 1 b) |
| rd_go_i | input | 2 | Per-port read go pulses |
| src_a_i | input | 16 | Operand a value, valid with rd_go_i[0] |
| src_b_i | input | 16 | Operand b value, valid with rd_go_i[1] |
| rd_rel_o | output | 2 | Per-port read release |
| wr_go_i | input | 1 | Write go pulse accepting the result |
| wr_rel_o | output | 1 | Write release, result pending |
| result_o | output | 16 | Result value |
| busy_o | output | 1 | Unit is busy with an instruction |

## Verification
Two events can fall in the same cycle: the last read go arrives, and the datapath computes the result from that same go data. The bench provokes this by pulsing both read go lines in the first cycle their releases are high. It also pulses a single late go after the other port has already been collected. In each case it checks that write release is high in the very next cycle with the correct sum, which shows that the source value went straight through to the datapath and was not taken a cycle late.

// File: rtl/fuh_pkg.sv
package fuh_pkg;
    localparam int unsigned OP_W  = 2;
    localparam int unsigned NRD   = 2;
    localparam int unsigned PORT_A = 0;
    localparam int unsigned PORT_B = 1;

    localparam logic [OP_W-1:0] OPC_PASS = 2'd0;
    localparam logic [OP_W-1:0] OPC_ADD  = 2'd1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } fu_state_e;
endpackage

// File: rtl/fuh_rdport.sv
module fuh_rdport #(
    parameter int unsigned W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic         need_i,
    input  logic [W-1:0] init_i,
    input  logic         go_i,
    input  logic [W-1:0] src_i,
    output logic         rel_o,
    output logic         pend_o,
    output logic [W-1:0] val_o
);
    typedef struct packed {
        logic         rel;
        logic [W-1:0] val;
    } port_t;

    port_t st_d, st_q;
    logic  take;

    assign take = st_q.rel && go_i;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.rel = need_i;
            st_d.val = init_i;
        end else if (take) begin
            st_d.rel = 1'b0;
            st_d.val = src_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rel_o  = st_q.rel;
    assign pend_o = st_q.rel && !go_i;
    assign val_o  = take ? src_i : st_q.val;
endmodule

// File: rtl/fuh_alu.sv
module fuh_alu #(
    parameter int unsigned W = 16
) (
    input  logic [fuh_pkg::OP_W-1:0] op_i,
    input  logic                     inv_i,
    input  logic [W-1:0]             a_i,
    input  logic [W-1:0]             b_i,
    output logic [W-1:0]             y_o
);
    import fuh_pkg::*;
    logic [W-1:0] a_eff;

    always_comb begin
        a_eff = inv_i ? ~a_i : a_i;
        if (op_i == OPC_ADD) y_o = a_eff + b_i;
        else                 y_o = a_eff;
    end
endmodule

// File: rtl/fuh_ctrl.sv
module fuh_ctrl #(
    parameter int unsigned W = 16
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     issue_i,
    input  logic [fuh_pkg::OP_W-1:0] op_i,
    input  logic                     inv_i,
    input  logic [fuh_pkg::NRD-1:0]  pend_i,
    input  logic [W-1:0]             alu_y_i,
    input  logic                     wr_go_i,
    output logic                     start_o,
    output logic [fuh_pkg::OP_W-1:0] op_o,
    output logic                     inv_o,
    output logic                     busy_o,
    output logic                     wr_rel_o,
    output logic [W-1:0]             result_o
);
    import fuh_pkg::*;

    typedef struct packed {
        fu_state_e       state;
        logic [OP_W-1:0] op;
        logic            inv;
        logic [W-1:0]    res;
    } ctrl_t;

    ctrl_t c_d, c_q;

    assign start_o = issue_i && (c_q.state == ST_IDLE);

    always_comb begin
        c_d = c_q;
        unique case (c_q.state)
            ST_IDLE: begin
                if (issue_i) begin
                    c_d.state = ST_READ;
                    c_d.op    = op_i;
                    c_d.inv   = inv_i;
                end
            end
            ST_READ: begin
                if (pend_i == '0) begin
                    c_d.state = ST_WRITE;
                    c_d.res   = alu_y_i;
                end
            end
            ST_WRITE: begin
                if (wr_go_i) c_d.state = ST_IDLE;
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) c_q <= '{state: ST_IDLE, op: '0, inv: 1'b0, res: '0};
        else         c_q <= c_d;
    end

    assign op_o     = c_q.op;
    assign inv_o    = c_q.inv;
    assign busy_o   = c_q.state != ST_IDLE;
    assign wr_rel_o = c_q.state == ST_WRITE;
    assign result_o = c_q.res;
endmodule

// File: rtl/fu_handshake_unit.sv
module fu_handshake_unit #(
    parameter int unsigned W = 16
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     issue_i,
    input  logic [fuh_pkg::OP_W-1:0] op_i,
    input  logic                     inv_a_i,
    input  logic                     zero_a_i,
    input  logic [W-1:0]             imm_i,
    input  logic                     imm_valid_i,
    input  logic [fuh_pkg::NRD-1:0]  rd_mask_i,
    input  logic [fuh_pkg::NRD-1:0]  rd_go_i,
    input  logic [W-1:0]             src_a_i,
    input  logic [W-1:0]             src_b_i,
    output logic [fuh_pkg::NRD-1:0]  rd_rel_o,
    input  logic                     wr_go_i,
    output logic                     wr_rel_o,
    output logic [W-1:0]             result_o,
    output logic                     busy_o
);
    import fuh_pkg::*;

    logic                start;
    logic [OP_W-1:0]     op_q;
    logic                inv_q;
    logic [NRD-1:0]      need;
    logic [NRD-1:0]      pend;
    logic [W-1:0]        init  [NRD];
    logic [W-1:0]        src   [NRD];
    logic [W-1:0]        opnd  [NRD];
    logic [W-1:0]        alu_y;

    always_comb begin
        need[PORT_A] = !rd_mask_i[PORT_A] && !zero_a_i;
        need[PORT_B] = !rd_mask_i[PORT_B] && !imm_valid_i;
        init[PORT_A] = '0;
        init[PORT_B] = imm_valid_i ? imm_i : '0;
        src[PORT_A]  = src_a_i;
        src[PORT_B]  = src_b_i;
    end

    fuh_ctrl #(.W(W)) u_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .issue_i  (issue_i),
        .op_i     (op_i),
        .inv_i    (inv_a_i),
        .pend_i   (pend),
        .alu_y_i  (alu_y),
        .wr_go_i  (wr_go_i),
        .start_o  (start),
        .op_o     (op_q),
        .inv_o    (inv_q),
        .busy_o   (busy_o),
        .wr_rel_o (wr_rel_o),
        .result_o (result_o)
    );

    for (genvar k = 0; k < NRD; k++) begin : g_rd
        fuh_rdport #(.W(W)) u_port (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .start_i (start),
            .need_i  (need[k]),
            .init_i  (init[k]),
            .go_i    (rd_go_i[k]),
            .src_i   (src[k]),
            .rel_o   (rd_rel_o[k]),
            .pend_o  (pend[k]),
            .val_o   (opnd[k])
        );
    end

    fuh_alu #(.W(W)) u_alu (
        .op_i  (op_q),
        .inv_i (inv_q),
        .a_i   (opnd[PORT_A]),
        .b_i   (opnd[PORT_B]),
        .y_o   (alu_y)
    );
endmodule

// File: rtl/fuh_checker.sv
module fuh_checker #(
    parameter int unsigned W = 16
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         issue_i,
    input logic         busy_o,
    input logic [1:0]   rd_mask_i,
    input logic [1:0]   rd_go_i,
    input logic [1:0]   rd_rel_o,
    input logic         wr_go_i,
    input logic         wr_rel_o,
    input logic [W-1:0] result_o
);
    p_busy_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o && issue_i |=> busy_o);
    p_busy_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o && !(wr_rel_o && wr_go_i) |=> busy_o);
    p_busy_fall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_rel_o && wr_go_i |=> !busy_o);
    p_no_spont_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o && !issue_i |=> !busy_o);
    p_rel_hold_a_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_rel_o[0] && !rd_go_i[0] |=> rd_rel_o[0]);
    p_rel_hold_b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_rel_o[1] && !rd_go_i[1] |=> rd_rel_o[1]);
    p_rel_drop_a_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_rel_o[0] && rd_go_i[0] |=> !rd_rel_o[0]);
    p_rel_drop_b_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_rel_o[1] && rd_go_i[1] |=> !rd_rel_o[1]);
    p_rel_only_after_issue_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rd_rel_o[0]) || $rose(rd_rel_o[1]) |-> $past(issue_i));
    p_mask_a_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o && issue_i && rd_mask_i[0] |=> !rd_rel_o[0]);
    p_mask_b_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o && issue_i && rd_mask_i[1] |=> !rd_rel_o[1]);
    p_wr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_rel_o && !wr_go_i |=> wr_rel_o && $stable(result_o));
    p_wr_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_rel_o |-> rd_rel_o == 2'b00);
endmodule

bind fu_handshake_unit fuh_checker #(.W(W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .issue_i   (issue_i),
    .busy_o    (busy_o),
    .rd_mask_i (rd_mask_i),
    .rd_go_i   (rd_go_i),
    .rd_rel_o  (rd_rel_o),
    .wr_go_i   (wr_go_i),
    .wr_rel_o  (wr_rel_o),
    .result_o  (result_o)
);

// File: tb/fu_handshake_unit_test.sv
`timescale 1ns/1ps
module fu_handshake_unit_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         issue = 1'b0;
    logic [1:0]   op = '0;
    logic         inv_a = 1'b0, zero_a = 1'b0, imm_valid = 1'b0;
    logic [W-1:0] imm = '0, src_a = '0, src_b = '0;
    logic [1:0]   rd_mask = '0, rd_go = '0, rd_rel;
    logic         wr_go = 1'b0, wr_rel, busy;
    logic [W-1:0] result;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fu_handshake_unit #(.W(W)) uut (
        .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .op_i(op),
        .inv_a_i(inv_a), .zero_a_i(zero_a), .imm_i(imm), .imm_valid_i(imm_valid),
        .rd_mask_i(rd_mask), .rd_go_i(rd_go), .src_a_i(src_a), .src_b_i(src_b),
        .rd_rel_o(rd_rel), .wr_go_i(wr_go), .wr_rel_o(wr_rel),
        .result_o(result), .busy_o(busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Issue in one cycle; on return the unit is in its first busy cycle.
    // Option inputs are scrambled after issue to prove they were captured.
    task automatic issue_op(input logic [1:0] o, input logic inv, input logic zr,
                            input logic [W-1:0] im, input logic imv, input logic [1:0] msk);
        @(negedge clk);
        issue = 1'b1; op = o; inv_a = inv; zero_a = zr; imm = im; imm_valid = imv;
        rd_mask = msk;
        @(negedge clk);
        issue = 1'b0; op = ~o; inv_a = ~inv; zero_a = ~zr; imm = ~im; imm_valid = ~imv;
        chk("R1 busy after issue", busy, 1);
    endtask

    task automatic read_go(input logic [1:0] g, input logic [W-1:0] a, input logic [W-1:0] b);
        rd_go = g; src_a = a; src_b = b;
        @(negedge clk);
        rd_go = '0; src_a = 16'hDEAD; src_b = 16'hBEEF;
    endtask

    task automatic finish_wr(input string tag, input logic [W-1:0] exp);
        chk({tag, " wr_rel"}, wr_rel, 1);
        chk({tag, " result"}, result, exp);
        chk("R1 busy held until write go", busy, 1);
        wr_go = 1'b1;
        @(negedge clk);
        wr_go = 1'b0;
        chk("R1 busy falls after write go", busy, 0);
        chk("R11 wr_rel falls", wr_rel, 0);
        rd_mask = '0;
    endtask

    task automatic t_reset;
        chk("R2 reset busy", busy, 0);
        chk("R2 reset rd_rel", rd_rel, 0);
        chk("R2 reset wr_rel", wr_rel, 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R2 no busy without issue", busy, 0);
        end
    endtask

    task automatic t_add_same_cycle;
        issue_op(2'd1, 0, 0, 16'd0, 0, 2'b00);
        chk("R4 both releases rise", rd_rel, 2'b11);
        read_go(2'b11, 16'd5, 16'd2);
        chk("R5 releases drop", rd_rel, 2'b00);
        finish_wr("R6 R10 add 5+2", 16'd7);
    endtask

    task automatic t_invert;
        issue_op(2'd1, 1, 0, 16'd0, 0, 2'b00);
        read_go(2'b11, 16'd5, 16'd2);
        finish_wr("R9 R3 inverted add", 16'd65532);
    endtask

    task automatic t_stall;
        issue_op(2'd1, 0, 0, 16'd0, 0, 2'b00);
        read_go(2'b01, 16'd100, 16'd0);
        chk("R5 rel a dropped", rd_rel[0], 0);
        chk("R4 rel b held", rd_rel[1], 1);
        for (int i = 0; i < 3; i++) begin
            if (i == 1) begin
                rd_go = 2'b01; src_a = 16'd999;
            end
            @(negedge clk);
            rd_go = '0;
            chk("R5 rel a stays low", rd_rel[0], 0);
            chk("R4 rel b stalls high", rd_rel[1], 1);
            chk("R11 no wr_rel during stall", wr_rel, 0);
        end
        read_go(2'b10, 16'd0, 16'd23);
        chk("R11 wr_rel after last go", wr_rel, 1);
        chk("R11 late go result", result, 16'd123);
        wr_go = 1'b0;
        rd_go = 2'b11; src_a = 16'd7; src_b = 16'd7;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            rd_go = '0;
            chk("R11 result held", result, 16'd123);
            chk("R5 no re-release", rd_rel, 0);
        end
        finish_wr("R11 delayed write", 16'd123);
    endtask

    task automatic t_imm;
        issue_op(2'd1, 0, 0, 16'd8, 1, 2'b00);
        chk("R8 imm: only rel a", rd_rel, 2'b01);
        read_go(2'b01, 16'd5, 16'd0);
        finish_wr("R8 imm add", 16'd13);
    endtask

    task automatic t_zero;
        issue_op(2'd1, 0, 1, 16'd0, 0, 2'b00);
        chk("R8 zero-a: only rel b", rd_rel, 2'b10);
        read_go(2'b10, 16'd0, 16'd2);
        finish_wr("R8 zero-a add", 16'd2);
    endtask

    task automatic t_mask;
        issue_op(2'd1, 0, 0, 16'd0, 0, 2'b10);
        chk("R7 mask b: only rel a", rd_rel, 2'b01);
        read_go(2'b01, 16'd5, 16'd0);
        finish_wr("R7 mask b add", 16'd5);
        issue_op(2'd1, 0, 0, 16'd0, 0, 2'b11);
        chk("R7 mask both: no rel", rd_rel, 2'b00);
        @(negedge clk);
        finish_wr("R7 R11 no operand", 16'd0);
    endtask

    task automatic t_pass;
        issue_op(2'd0, 0, 0, 16'd0, 0, 2'b00);
        read_go(2'b11, 16'd9, 16'd2);
        finish_wr("R10 pass code 0", 16'd9);
        issue_op(2'd3, 0, 0, 16'd0, 0, 2'b00);
        read_go(2'b11, 16'd41, 16'd2);
        finish_wr("R10 pass code 3", 16'd41);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add_same_cycle();
        t_invert();
        t_stall();
        t_imm();
        t_zero();
        t_mask();
        t_pass();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule